// File: doc/BRIEF.md
# Sixteen-Bit Timer with Clear-on-Match Modes

The block is a 16-bit up-counter advanced by a timer clock enable. A 4-bit waveform-mode field selects how the count runs: free-running with wrap, clear when the count reaches compare register A, or clear when it reaches the capture register. In both clear modes the chosen register sets the top value, and with it the period.

One output pin responds to compare A matches. A 2-bit output-mode field makes a match hold, toggle, clear or set the pin. This field has no effect on the count sequence. Three sticky event flags (overflow, compare A, capture/top) are set by hardware. Software clears them with a write-one-to-clear port or with per-flag interrupt acknowledge inputs.

Software can write the counter, compare A and capture registers at any time. A counter write takes priority over counting in the cycle it happens.

Top module: `tmr16_ctc`

## Requirements
- R1: After reset the count is 0, the compare A and capture registers are 0, all three flags are 0 and the pin is 0.
- R2: The count changes only on a cycle with `tick_i` high. A cycle with `cnt_we_i` high loads `cnt_wdata_i` and overrides the increment and the clear. Such a write cycle sets no flag and triggers no pin action.
- R3: With waveform mode 0, and with any mode value other than 4 and 12, the count increments, wraps from 0xFFFF to 0x0000 and is never cleared by a match.
- R4: The overflow flag (flag bit 0) is set on the same edge where a tick moves the count from 0xFFFF to 0. This holds in every mode, so the flag and the zero count appear together.
- R5: With waveform mode 4, a tick at count == compare A returns the count to 0 and sets the compare A flag (flag bit 1) on that same edge.
- R6: With waveform mode 12, a tick at count == capture returns the count to 0 and sets the capture flag (flag bit 2). The capture flag is set in no other case.
- R7: A tick at count == compare A sets the compare A flag in every mode, including the free-running one.
- R8: On a compare A match the pin acts by output mode: 0 holds, 1 toggles, 2 clears, 3 sets. The output mode never alters the count sequence.
- R9: A flag is cleared by `flag_clr_we_i` with a 1 in its bit of `flag_clr_data_i`, or by its bit of `flag_ack_i` (bit 0 overflow, bit 1 compare A, bit 2 capture). If a hardware set and a clear fall in the same cycle, the set wins.
- R10: A compare A or capture write takes effect from the next edge. A match on the write edge uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer clock enable |
| wave_mode_i | input | 4 | Waveform mode (0 free, 4 top=compare A, 12 top=capture) |
| out_mode_i | input | 2 | Pin action on compare A match |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 16 | Counter write data |
| cmpa_we_i | input | 1 | Compare A write strobe |
| cmpa_wdata_i | input | 16 | Compare A write data |
| cap_we_i | input | 1 | Capture register write strobe |
| cap_wdata_i | input | 16 | Capture register write data |
| flag_clr_we_i | input | 1 | Flag clear write strobe |
| flag_clr_data_i | input | 3 | Write-one-to-clear mask |
| flag_ack_i | input | 3 | Interrupt acknowledge per flag |
| count_o | output | 16 | Current count |
| ovf_flag_o | output | 1 | Overflow flag |
| cmpa_flag_o | output | 1 | Compare A flag |
| cap_flag_o | output | 1 | Capture/top flag |
| wave_pin_o | output | 1 | Compare output pin |

## Verification
Two pairs of functions can land in one cycle. The first pair is a hardware flag set and a software clear of the same flag. The bench stages this by placing the count at compare A and issuing a tick together with a write-one-to-clear of that bit; the flag must read 1 afterwards. The second pair is a counter write and a tick at a match point. This is driven with the count sitting at the top value in mode 4, and is judged by the count taking the written value with no flag set and no pin change.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [1:0] {
    RUN_FREE     = 2'd0,
    RUN_TOP_CMPA = 2'd1,
    RUN_TOP_CAP  = 2'd2
  } run_mode_e;

  typedef enum logic [1:0] {
    PIN_HOLD   = 2'd0,
    PIN_TOGGLE = 2'd1,
    PIN_CLEAR  = 2'd2,
    PIN_SET    = 2'd3
  } pin_act_e;

  localparam logic [3:0] WAVE_TOP_CMPA = 4'd4;
  localparam logic [3:0] WAVE_TOP_CAP  = 4'd12;

  localparam int FLAG_OVF  = 0;
  localparam int FLAG_CMPA = 1;
  localparam int FLAG_CAP  = 2;
  localparam int NUM_FLAGS = 3;

  function automatic run_mode_e decode_wave(input logic [3:0] w);
    case (w)
      WAVE_TOP_CMPA: return RUN_TOP_CMPA;
      WAVE_TOP_CAP:  return RUN_TOP_CAP;
      default:       return RUN_FREE;
    endcase
  endfunction
endpackage

// File: rtl/tmr16_counter.sv
module tmr16_counter
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  run_mode_e        mode_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cmpa_i,
  input  logic [CNT_W-1:0] cap_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_evt_o,
  output logic             cmpa_evt_o,
  output logic             cap_evt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] top_val;
  logic             advance;
  logic             top_hit;

  always_comb begin
    top_val = (mode_i == RUN_TOP_CAP) ? cap_i : cmpa_i;
    advance = tick_i && !we_i;
    top_hit = (mode_i != RUN_FREE) && (count_q == top_val);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (we_i) begin
      count_q <= wdata_i;
    end else if (tick_i) begin
      count_q <= top_hit ? '0 : count_q + CNT_ONE;
    end
  end

  assign count_o    = count_q;
  assign ovf_evt_o  = advance && (count_q == CNT_MAX);
  assign cmpa_evt_o = advance && (count_q == cmpa_i);
  assign cap_evt_o  = advance && (mode_i == RUN_TOP_CAP) && (count_q == cap_i);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !we_i) |=> $stable(count_o));
  assert_write_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (count_o == $past(wdata_i)));
  assert_wrap_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_o |=> (count_o == '0));
  assert_top_cmpa_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpa_evt_o && mode_i == RUN_TOP_CMPA) |=> (count_o == '0));
  assert_top_cap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_o |=> (count_o == '0));
endmodule

// File: rtl/tmr16_flags.sv
module tmr16_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;

    // hardware set beats any clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    flag_q <= 1'b0;
      else if (set_i[g])              flag_q <= 1'b1;
      else if (clr_i[g] || ack_i[g])  flag_q <= 1'b0;
    end

    assign flag_o[g] = flag_q;

    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_o[g]);
    assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[g] && (clr_i[g] || ack_i[g])) |=> !flag_o[g]);
    assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[g] && !clr_i[g] && !ack_i[g]) |=> $stable(flag_o[g]));
  end
endmodule

// File: rtl/tmr16_wave_out.sv
module tmr16_wave_out
  import tmr16_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     match_i,
  input  pin_act_e act_i,
  output logic     pin_o
);
  logic pin_q;
  logic pin_d;

  always_comb begin
    pin_d = pin_q;
    if (match_i) begin
      case (act_i)
        PIN_TOGGLE: pin_d = !pin_q;
        PIN_CLEAR:  pin_d = 1'b0;
        PIN_SET:    pin_d = 1'b1;
        default:    pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_d;
  end

  assign pin_o = pin_q;

  assert_pin_toggle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && act_i == PIN_TOGGLE) |=> (pin_o != $past(pin_o)));
  assert_pin_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && act_i == PIN_CLEAR) |=> !pin_o);
  assert_pin_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && act_i == PIN_SET) |=> pin_o);
  assert_pin_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_i || act_i == PIN_HOLD) |=> $stable(pin_o));
endmodule

// File: rtl/tmr16_ctc.sv
module tmr16_ctc
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [3:0]       wave_mode_i,
  input  logic [1:0]       out_mode_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             cmpa_we_i,
  input  logic [CNT_W-1:0] cmpa_wdata_i,
  input  logic             cap_we_i,
  input  logic [CNT_W-1:0] cap_wdata_i,
  input  logic             flag_clr_we_i,
  input  logic [2:0]       flag_clr_data_i,
  input  logic [2:0]       flag_ack_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_flag_o,
  output logic             cmpa_flag_o,
  output logic             cap_flag_o,
  output logic             wave_pin_o
);
  run_mode_e              run_mode;
  logic [CNT_W-1:0]       cmpa_q;
  logic [CNT_W-1:0]       cap_q;
  logic                   ovf_evt;
  logic                   cmpa_evt;
  logic                   cap_evt;
  logic [NUM_FLAGS-1:0]   flag_set;
  logic [NUM_FLAGS-1:0]   flag_clr;
  logic [NUM_FLAGS-1:0]   flags;

  assign run_mode = decode_wave(wave_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmpa_q <= '0;
      cap_q  <= '0;
    end else begin
      if (cmpa_we_i) cmpa_q <= cmpa_wdata_i;
      if (cap_we_i)  cap_q  <= cap_wdata_i;
    end
  end

  tmr16_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .mode_i     (run_mode),
    .we_i       (cnt_we_i),
    .wdata_i    (cnt_wdata_i),
    .cmpa_i     (cmpa_q),
    .cap_i      (cap_q),
    .count_o    (count_o),
    .ovf_evt_o  (ovf_evt),
    .cmpa_evt_o (cmpa_evt),
    .cap_evt_o  (cap_evt)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_OVF]  = ovf_evt;
    flag_set[FLAG_CMPA] = cmpa_evt;
    flag_set[FLAG_CAP]  = cap_evt;
    flag_clr            = flag_clr_we_i ? flag_clr_data_i : '0;
  end

  tmr16_flags #(.N(NUM_FLAGS)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .ack_i  (flag_ack_i),
    .flag_o (flags)
  );

  tmr16_wave_out u_pin (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .match_i (cmpa_evt),
    .act_i   (pin_act_e'(out_mode_i)),
    .pin_o   (wave_pin_o)
  );

  assign ovf_flag_o  = flags[FLAG_OVF];
  assign cmpa_flag_o = flags[FLAG_CMPA];
  assign cap_flag_o  = flags[FLAG_CAP];

  assert_cap_only_top_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_mode != RUN_TOP_CAP && !flag_clr_we_i && flag_ack_i == '0 && !cap_flag_o)
      |=> !cap_flag_o);
  assert_write_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_we_i && !cmpa_flag_o && !flag_clr_we_i && flag_ack_i == '0)
      |=> (!cmpa_flag_o && $stable(wave_pin_o)));
endmodule

// File: tb/sim_tmr16_ctc.sv
module sim_tmr16_ctc;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [3:0]  wave_mode_i = '0;
  logic [1:0]  out_mode_i = '0;
  logic        cnt_we_i = 1'b0;
  logic [15:0] cnt_wdata_i = '0;
  logic        cmpa_we_i = 1'b0;
  logic [15:0] cmpa_wdata_i = '0;
  logic        cap_we_i = 1'b0;
  logic [15:0] cap_wdata_i = '0;
  logic        flag_clr_we_i = 1'b0;
  logic [2:0]  flag_clr_data_i = '0;
  logic [2:0]  flag_ack_i = '0;
  logic [15:0] count_o;
  logic        ovf_flag_o, cmpa_flag_o, cap_flag_o, wave_pin_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = !clk;

  tmr16_ctc u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .wave_mode_i(wave_mode_i), .out_mode_i(out_mode_i),
    .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i),
    .cmpa_we_i(cmpa_we_i), .cmpa_wdata_i(cmpa_wdata_i),
    .cap_we_i(cap_we_i), .cap_wdata_i(cap_wdata_i),
    .flag_clr_we_i(flag_clr_we_i), .flag_clr_data_i(flag_clr_data_i),
    .flag_ack_i(flag_ack_i), .count_o(count_o),
    .ovf_flag_o(ovf_flag_o), .cmpa_flag_o(cmpa_flag_o),
    .cap_flag_o(cap_flag_o), .wave_pin_o(wave_pin_o)
  );

  typedef struct packed {
    logic [3:0]  mode;
    logic [1:0]  om;
    logic [15:0] cmpa;
    logic [15:0] cap;
    logic [15:0] start;
    logic [7:0]  nticks;
    logic [15:0] exp_cnt;
    logic [2:0]  exp_flags; // {cap, cmpa, ovf}
    logic        exp_pin;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  2'd1, 16'h0005, 16'h0000, 16'h0000, 8'd10, 16'h000A, 3'b010, 1'b1}, // R7 R8
    '{4'd0,  2'd0, 16'h0010, 16'h0000, 16'hFFFE, 8'd3,  16'h0001, 3'b001, 1'b0}, // R3 R4
    '{4'd4,  2'd1, 16'h0003, 16'h0000, 16'h0000, 8'd9,  16'h0001, 3'b010, 1'b0}, // R5 R8
    '{4'd4,  2'd3, 16'h0003, 16'h0000, 16'h0000, 8'd4,  16'h0000, 3'b010, 1'b1}, // R5 R8
    '{4'd12, 2'd1, 16'h0002, 16'h0004, 16'h0000, 8'd5,  16'h0000, 3'b110, 1'b1}, // R6 R7
    '{4'd12, 2'd2, 16'h0007, 16'h0004, 16'h0000, 8'd6,  16'h0001, 3'b100, 1'b0}, // R6
    '{4'd4,  2'd0, 16'h0003, 16'h0000, 16'hFFFF, 8'd2,  16'h0001, 3'b001, 1'b0}, // R4 R5
    '{4'd5,  2'd1, 16'h0002, 16'h0000, 16'h0000, 8'd4,  16'h0004, 3'b010, 1'b1}, // R3
    '{4'd8,  2'd3, 16'h0002, 16'h0002, 16'h0000, 8'd4,  16'h0004, 3'b010, 1'b1}, // R3 R6
    '{4'd4,  2'd0, 16'h0003, 16'h0000, 16'h0000, 8'd4,  16'h0000, 3'b010, 1'b0}, // R8
    '{4'd12, 2'd0, 16'h0000, 16'hFFFF, 16'hFFFE, 8'd2,  16'h0000, 3'b101, 1'b0}, // R4 R6
    '{4'd0,  2'd1, 16'hFFFF, 16'h0000, 16'hFFFD, 8'd3,  16'h0000, 3'b011, 1'b1}  // R4 R7
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    tick_i = 0; cnt_we_i = 0; cmpa_we_i = 0; cap_we_i = 0;
    flag_clr_we_i = 0; flag_clr_data_i = '0; flag_ack_i = '0;
    wave_mode_i = '0; out_mode_i = '0;
    rst_ni = 0;
    @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic setup(input logic [3:0] m, input logic [1:0] om,
                       input logic [15:0] a, input logic [15:0] c, input logic [15:0] s);
    @(negedge clk);
    wave_mode_i = m; out_mode_i = om;
    cmpa_we_i = 1; cmpa_wdata_i = a;
    cap_we_i = 1; cap_wdata_i = c;
    cnt_we_i = 1; cnt_wdata_i = s;
    @(negedge clk);
    cmpa_we_i = 0; cap_we_i = 0; cnt_we_i = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 count", 32'(count_o), 0);
    chk("R1 flags", 32'({cap_flag_o, cmpa_flag_o, ovf_flag_o}), 0);
    chk("R1 pin", 32'(wave_pin_o), 0);
    // R1 compare A resets to 0: a tick at count 0 matches
    @(negedge clk); tick_i = 1;
    @(negedge clk); tick_i = 0;
    chk("R1 cmpa reset value", 32'(cmpa_flag_o), 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      do_reset();
      setup(v.mode, v.om, v.cmpa, v.cap, v.start);
      tick_i = 1;
      repeat (int'(v.nticks)) @(negedge clk);
      tick_i = 0;
      chk($sformatf("vec%0d R3/R5/R6 count", i), 32'(count_o), 32'(v.exp_cnt));
      chk($sformatf("vec%0d R4/R6/R7 flags", i),
          32'({cap_flag_o, cmpa_flag_o, ovf_flag_o}), 32'(v.exp_flags));
      chk($sformatf("vec%0d R8 pin", i), 32'(wave_pin_o), 32'(v.exp_pin));
    end

    // R2 hold without tick, then advance
    do_reset();
    setup(4'd0, 2'd0, 16'h0100, 16'h0000, 16'h1234);
    repeat (5) @(negedge clk);
    chk("R2 hold", 32'(count_o), 32'h1234);
    tick_i = 1; @(negedge clk); tick_i = 0;
    chk("R2 advance", 32'(count_o), 32'h1235);

    // R2 write beats tick at top, no match side effects
    do_reset();
    setup(4'd4, 2'd1, 16'h0005, 16'h0000, 16'h0005);
    tick_i = 1; cnt_we_i = 1; cnt_wdata_i = 16'h0100;
    @(negedge clk);
    tick_i = 0; cnt_we_i = 0;
    chk("R2 write priority", 32'(count_o), 32'h0100);
    chk("R2 write no flag", 32'(cmpa_flag_o), 0);
    chk("R2 write no pin", 32'(wave_pin_o), 0);
    tick_i = 1; @(negedge clk); tick_i = 0;
    chk("R2 after write", 32'(count_o), 32'h0101);

    // R9 set wins over clear, then clears work
    do_reset();
    setup(4'd0, 2'd0, 16'h0005, 16'h0000, 16'h0005);
    tick_i = 1; flag_clr_we_i = 1; flag_clr_data_i = 3'b010;
    @(negedge clk);
    tick_i = 0;
    chk("R9 set wins", 32'(cmpa_flag_o), 1);
    @(negedge clk);
    flag_clr_we_i = 0; flag_clr_data_i = '0;
    chk("R9 w1c clear", 32'(cmpa_flag_o), 0);
    cnt_we_i = 1; cnt_wdata_i = 16'hFFFF;
    @(negedge clk); cnt_we_i = 0; tick_i = 1;
    @(negedge clk); tick_i = 0;
    chk("R9 ovf set", 32'(ovf_flag_o), 1);
    flag_clr_we_i = 1; flag_clr_data_i = 3'b110;
    @(negedge clk); flag_clr_we_i = 0; flag_clr_data_i = '0;
    chk("R9 mask leaves other bit", 32'(ovf_flag_o), 1);
    flag_ack_i = 3'b001;
    @(negedge clk); flag_ack_i = '0;
    chk("R9 ack clear", 32'(ovf_flag_o), 0);

    // R10 compare write uses old value on its own edge
    do_reset();
    setup(4'd0, 2'd0, 16'h0009, 16'h0000, 16'h0005);
    tick_i = 1; cmpa_we_i = 1; cmpa_wdata_i = 16'h0005;
    @(negedge clk);
    tick_i = 0; cmpa_we_i = 0;
    chk("R10 old value on write edge", 32'(cmpa_flag_o), 0);
    chk("R10 count", 32'(count_o), 32'h0006);
    cnt_we_i = 1; cnt_wdata_i = 16'h0005;
    @(negedge clk); cnt_we_i = 0; tick_i = 1;
    @(negedge clk); tick_i = 0;
    chk("R10 new value used", 32'(cmpa_flag_o), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule